// File: doc/BRIEF.md
# Shift and Status-Flag Unit

This block is the shift and add/subtract/compare stage of a 16-bit integer datapath. Each request supplies a destination operand and a source operand, a function select, a byte-mode bit, the shift-control field of the instruction and the low bits of register 0. One clock later the block presents a registered result and a registered copy of the 16-bit status word. The six condition flags in that word have been recomputed. Every other status bit is copied through from the status input.

The shifter covers four kinds of shift: arithmetic right, logical right, arithmetic left and circular right. The shift amount comes from the instruction field. When that field is zero it falls back to register 0, and when that is also zero the operand is shifted by the full word width. The adder handles word and byte add, subtract and compare.

The status word uses these bit positions: logical greater 15, arithmetic greater 14, equal 13, carry 12, overflow 11, odd parity 10, overflow interrupt enable 5, and the interrupt mask in bits 3:0. Operand fetch and writeback are handled by the surrounding datapath.

Top module: `shift_flag_unit`

## Requirements
- R1: After reset, `result_o`, `status_o`, `done_o` and `ovf_req_o` are all zero. A request sampled with `start_i` high at a rising edge raises `done_o` and updates `result_o` and `status_o` after that edge. At an edge where `start_i` is low, `done_o` goes low and `result_o` and `status_o` keep their values, whatever the other inputs carry.
- R2: `func_i` selects the operation: 0 shift, 1 add, 2 subtract, 3 compare. For a shift, `shift_ctl_i[5:4]` (instruction bits 9:8) selects the kind: 0 arithmetic right, 1 logical right, 2 arithmetic left, 3 circular right. The kind is applied to `dst_i`, and `result_o` holds the shifted word.
- R3: The shift count is `shift_ctl_i[3:0]` (instruction bits 7:4). If that field is zero, the count is `r0_low_i`. If both are zero, the count is 16.
- R4: On every shift, carry (bit 12) is the last bit shifted out. For right shifts this is operand bit count-1. For the left shift it is operand bit 16-count. For the circular shift it equals the resulting bit 15.
- R5: The arithmetic left shift sets overflow (bit 11) when the top count+1 bits of the operand, with a zero appended below bit 0, are not all equal, and clears it otherwise. The other three shifts leave overflow as supplied on `status_i`.
- R6: After a shift, add or subtract, logical greater (bit 15) is set for a nonzero result, arithmetic greater (bit 14) for a result that is positive as a signed number, and equal (bit 13) for a zero result. Byte operations judge these on the 8-bit result.
- R7: Add computes `dst_i + src_i`. Carry is the carry out of the top bit. Overflow is set when the sign of the result differs from the signs of both operands.
- R8: Subtract computes `dst_i - src_i`. Carry is set when no borrow occurs. Overflow is set when the operands differ in sign and the sign of the result differs from that of `dst_i`.
- R9: With `byte_i` high, add, subtract and compare use only bits 7:0 of both operands, and carry and overflow are taken at bit 7. For byte add and subtract, `result_o[7:0]` holds the result with bits 15:8 zero, and odd parity (bit 10) is set when the result has an odd number of ones. Shifts and word operations leave parity as supplied.
- R10: Compare sets arithmetic greater when `src_i` > `dst_i` as signed numbers, logical greater when `src_i` > `dst_i` as unsigned numbers, and equal when they match. It leaves carry, overflow and parity as supplied, and `result_o` takes `dst_i`.
- R11: Status bits 9:0, which include the interrupt mask (3:0) and the overflow interrupt enable (5), are copied from `status_i` on every request.
- R12: `ovf_req_o` is high exactly while `status_o` has both bit 5 (overflow interrupt enable) and bit 11 (overflow) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle per operation |
| func_i | input | 2 | Operation select: shift, add, subtract, compare |
| byte_i | input | 1 | Byte mode for add, subtract and compare |
| shift_ctl_i | input | 6 | Instruction bits 9:4: shift kind [5:4], count field [3:0] |
| r0_low_i | input | 4 | Low four bits of register 0, the fallback count |
| dst_i | input | 16 | Destination operand; shift operand; minuend |
| src_i | input | 16 | Source operand; addend; subtrahend |
| status_i | input | 16 | Current status word |
| result_o | output | 16 | Registered result |
| status_o | output | 16 | Registered updated status word |
| done_o | output | 1 | High the cycle after an accepted request |
| ovf_req_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds two copies at DATA_W = 16: one with SHIFT_IMPL = 0, which uses a single shift operator, and one with SHIFT_IMPL = 1, which uses a staged shifter. Both are compared against the same step-by-step model. The staged copy is where carry tracking through the stages and overflow accumulation across the stages can go wrong, so count 16 and counts that take several stages are aimed at it. The fallback count of 16 is reached through an all-zero instruction field and low register bits that are all zero.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   localparam int ST_W    = 16;
   localparam int SB_LGT  = 15;
   localparam int SB_AGT  = 14;
   localparam int SB_EQ   = 13;
   localparam int SB_CY   = 12;
   localparam int SB_OV   = 11;
   localparam int SB_PAR  = 10;
   localparam int SB_OVIE = 5;

   typedef enum logic [1:0] {
      FN_SHIFT = 2'd0,
      FN_ADD   = 2'd1,
      FN_SUB   = 2'd2,
      FN_CMP   = 2'd3
   } fn_e;

   // kind encoding is decoded from instruction bits 9:8
   typedef enum logic [1:0] {
      SH_SRA = 2'd0,
      SH_SRL = 2'd1,
      SH_SLA = 2'd2,
      SH_SRC = 2'd3
   } sh_e;
endpackage

// File: rtl/sfu_count.sv
module sfu_count #(
   parameter int CNT_W = 4
) (
   input  logic [CNT_W-1:0] field_i,
   input  logic [CNT_W-1:0] reg_i,
   output logic [CNT_W:0]   cnt_o
);
   localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

   always_comb begin
      if (field_i != '0)
         cnt_o = {1'b0, field_i};
      else if (reg_i != '0)
         cnt_o = {1'b0, reg_i};
      else
         cnt_o = FULL;
   end
endmodule

// File: rtl/sfu_shift.sv
module sfu_shift
   import sfu_pkg::*;
#(
   parameter int W    = 16,
   parameter int IMPL = 0,
   localparam int CNT_W = $clog2(W)
) (
   input  sh_e            kind_i,
   input  logic [W-1:0]   val_i,
   input  logic [CNT_W:0] cnt_i,
   output logic [W-1:0]   res_o,
   output logic           cy_o,
   output logic           ov_o
);
   if (IMPL == 0) begin : g_direct
      logic [CNT_W-1:0] cm1;
      logic [W:0]       msk, win;
      logic [W-1:0]     res;
      logic             cy, ov;

      always_comb begin
         // count is never zero here, so count-1 fits CNT_W bits
         cm1 = CNT_W'(cnt_i - 1'b1);
         msk = ~({(W+1){1'b1}} >> (int'(cnt_i) + 1));
         win = {val_i, 1'b0} & msk;
         ov  = 1'b0;
         cy  = val_i[cm1];
         unique case (kind_i)
            SH_SRA: res = $signed(val_i) >>> cnt_i;
            SH_SRL: res = val_i >> cnt_i;
            SH_SLA: begin
               res = val_i << cnt_i;
               cy  = val_i[~cm1];
               ov  = (win != '0) && (win != msk);
            end
            default: res = (val_i >> cnt_i) | (val_i << (W - int'(cnt_i)));
         endcase
      end

      assign res_o = res;
      assign cy_o  = cy;
      assign ov_o  = ov;
   end else begin : g_staged
      localparam int NSTG = CNT_W + 1;
      logic [NSTG:0][W-1:0] d_stg;
      logic [NSTG:0]        g_stg;
      logic [NSTG:0]        v_stg;

      assign d_stg[0] = val_i;
      assign g_stg[0] = 1'b0;
      assign v_stg[0] = 1'b0;

      for (genvar s = 0; s < NSTG; s++) begin : g_stage
         localparam int K = 1 << s;
         localparam logic [W:0] WMSK = ~({(W+1){1'b1}} << (K + 1));
         logic [W-1:0] d_in, d_nx, up;
         logic [W:0]   tw;
         logic         g_nx, v_nx;

         assign d_in = d_stg[s];

         always_comb begin
            up   = (kind_i == SH_SRC) ? d_in : {W{(kind_i == SH_SRA) & d_in[W-1]}};
            tw   = ({d_in, 1'b0} >> (W - K)) & WMSK;
            v_nx = 1'b0;
            if (kind_i == SH_SLA) begin
               {g_nx, d_nx} = (W+1)'({1'b0, d_in} << K);
               v_nx = (tw != '0) && (tw != WMSK);
            end else begin
               {d_nx, g_nx} = (W+1)'({up, d_in, 1'b0} >> K);
            end
         end

         assign d_stg[s+1] = cnt_i[s] ? d_nx : d_in;
         assign g_stg[s+1] = cnt_i[s] ? g_nx : g_stg[s];
         assign v_stg[s+1] = v_stg[s] | (cnt_i[s] & v_nx);
      end

      assign res_o = d_stg[NSTG];
      assign cy_o  = g_stg[NSTG];
      assign ov_o  = v_stg[NSTG];
   end
endmodule

// File: rtl/sfu_arith.sv
module sfu_arith
   import sfu_pkg::*;
#(
   parameter int W = 16
) (
   input  fn_e          fn_i,
   input  logic         byte_i,
   input  logic [W-1:0] dst_i,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] res_o,
   output logic         cy_o,
   output logic         ov_o,
   output logic         gtu_o,
   output logic         gts_o,
   output logic         eq_o,
   output logic         par_o
);
   localparam int B = W / 2;

   logic [W-1:0] a_j, b_j, r_j;
   logic [W:0]   sum;
   logic         is_sub;

   always_comb begin
      // byte operands are moved to the top so that carry and sign land at bit W
      a_j    = byte_i ? {dst_i[B-1:0], {B{1'b0}}} : dst_i;
      b_j    = byte_i ? {src_i[B-1:0], {B{1'b0}}} : src_i;
      is_sub = (fn_i == FN_SUB);
      sum    = is_sub ? ({1'b0, a_j} - {1'b0, b_j}) : ({1'b0, a_j} + {1'b0, b_j});
      r_j    = sum[W-1:0];
      cy_o   = is_sub ? ~sum[W] : sum[W];
      ov_o   = is_sub ? ((a_j[W-1] ^ b_j[W-1]) & (a_j[W-1] ^ r_j[W-1]))
                      : ((r_j[W-1] ^ a_j[W-1]) & (r_j[W-1] ^ b_j[W-1]));
      par_o  = ^r_j[W-1 -: B];
      if (fn_i == FN_CMP) begin
         gts_o = $signed(b_j) > $signed(a_j);
         gtu_o = b_j > a_j;
         eq_o  = (a_j == b_j);
         res_o = dst_i;
      end else begin
         eq_o  = (r_j == '0);
         gtu_o = ~eq_o;
         gts_o = ~eq_o & ~r_j[W-1];
         res_o = byte_i ? (r_j >> B) : r_j;
      end
   end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
   import sfu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int SHIFT_IMPL = 0,
   localparam int CNT_W = $clog2(DATA_W),
   localparam int CTL_W = CNT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        func_i,
   input  logic              byte_i,
   input  logic [CTL_W-1:0]  shift_ctl_i,
   input  logic [CNT_W-1:0]  r0_low_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [ST_W-1:0]   status_i,
   output logic [DATA_W-1:0] result_o,
   output logic [ST_W-1:0]   status_o,
   output logic              done_o,
   output logic              ovf_req_o
);
   if (DATA_W < 8 || DATA_W > 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("shift_flag_unit: DATA_W must be 8 or 16");
   end
   if (SHIFT_IMPL < 0 || SHIFT_IMPL > 1) begin : g_bad_impl
      $error("shift_flag_unit: SHIFT_IMPL must be 0 or 1");
   end

   fn_e              fn;
   sh_e              kind;
   logic [CNT_W:0]   cnt;
   logic [DATA_W-1:0] sh_res, ar_res, res_nx;
   logic             sh_cy, sh_ov, sh_zero;
   logic             ar_cy, ar_ov, ar_gtu, ar_gts, ar_eq, ar_par;
   logic [ST_W-1:0]  st_nx;

   assign fn   = fn_e'(func_i);
   assign kind = sh_e'(shift_ctl_i[CTL_W-1 -: 2]);

   sfu_count #(.CNT_W(CNT_W)) u_count (
      .field_i (shift_ctl_i[CNT_W-1:0]),
      .reg_i   (r0_low_i),
      .cnt_o   (cnt)
   );

   sfu_shift #(.W(DATA_W), .IMPL(SHIFT_IMPL)) u_shift (
      .kind_i (kind),
      .val_i  (dst_i),
      .cnt_i  (cnt),
      .res_o  (sh_res),
      .cy_o   (sh_cy),
      .ov_o   (sh_ov)
   );

   sfu_arith #(.W(DATA_W)) u_arith (
      .fn_i   (fn),
      .byte_i (byte_i),
      .dst_i  (dst_i),
      .src_i  (src_i),
      .res_o  (ar_res),
      .cy_o   (ar_cy),
      .ov_o   (ar_ov),
      .gtu_o  (ar_gtu),
      .gts_o  (ar_gts),
      .eq_o   (ar_eq),
      .par_o  (ar_par)
   );

   assign sh_zero = (sh_res == '0);

   always_comb begin
      st_nx  = status_i;
      res_nx = ar_res;
      unique case (fn)
         FN_SHIFT: begin
            res_nx         = sh_res;
            st_nx[SB_LGT]  = ~sh_zero;
            st_nx[SB_AGT]  = ~sh_zero & ~sh_res[DATA_W-1];
            st_nx[SB_EQ]   = sh_zero;
            st_nx[SB_CY]   = sh_cy;
            if (kind == SH_SLA) st_nx[SB_OV] = sh_ov;
         end
         FN_ADD, FN_SUB: begin
            st_nx[SB_LGT] = ar_gtu;
            st_nx[SB_AGT] = ar_gts;
            st_nx[SB_EQ]  = ar_eq;
            st_nx[SB_CY]  = ar_cy;
            st_nx[SB_OV]  = ar_ov;
            if (byte_i) st_nx[SB_PAR] = ar_par;
         end
         default: begin
            st_nx[SB_LGT] = ar_gtu;
            st_nx[SB_AGT] = ar_gts;
            st_nx[SB_EQ]  = ar_eq;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         status_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            result_o <= res_nx;
            status_o <= st_nx;
         end
      end
   end

   assign ovf_req_o = status_o[SB_OVIE] & status_o[SB_OV];
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
   import sfu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        func_i,
   input logic              byte_i,
   input logic [1:0]        kind_i,
   input logic [ST_W-1:0]   status_i,
   input logic [ST_W-1:0]   status_o,
   input logic [DATA_W-1:0] result_o,
   input logic              done_o
);
   a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   a_r1_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);

   a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(result_o) && $stable(status_o)));

   a_r11_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (status_o[SB_PAR-1:0] == $past(status_i[SB_PAR-1:0])));

   a_r10_cmp_keeps_cov: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && func_i == FN_CMP) |=>
         (status_o[SB_CY:SB_PAR] == $past(status_i[SB_CY:SB_PAR])));

   a_r5_ov_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && func_i == FN_SHIFT && kind_i != SH_SLA) |=>
         (status_o[SB_OV] == $past(status_i[SB_OV])));

   a_r6_flag_consistency: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && func_i != FN_CMP) |=>
         (!(status_o[SB_EQ] && status_o[SB_LGT]) && (!status_o[SB_AGT] || status_o[SB_LGT])));

   a_r9_par_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (func_i == FN_SHIFT || !byte_i)) |=>
         (status_o[SB_PAR] == $past(status_i[SB_PAR])));
endmodule

bind shift_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .func_i   (func_i),
   .byte_i   (byte_i),
   .kind_i   (shift_ctl_i[CTL_W-1 -: 2]),
   .status_i (status_i),
   .status_o (status_o),
   .result_o (result_o),
   .done_o   (done_o)
);

// File: tb/shift_flag_unit_bench.sv
`timescale 1ns/1ps
module shift_flag_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, bm;
   logic [1:0]  fn;
   logic [5:0]  ctl;
   logic [3:0]  r0l;
   logic [15:0] dst, src, sti;

   logic [15:0] res0, st0, res1, st1;
   logic        dn0, rq0, dn1, rq1;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   shift_flag_unit #(.DATA_W(16), .SHIFT_IMPL(0)) u_shift_flag_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(fn), .byte_i(bm),
      .shift_ctl_i(ctl), .r0_low_i(r0l), .dst_i(dst), .src_i(src), .status_i(sti),
      .result_o(res0), .status_o(st0), .done_o(dn0), .ovf_req_o(rq0));

   shift_flag_unit #(.DATA_W(16), .SHIFT_IMPL(1)) u_shift_flag_unit_staged (
      .clk(clk), .rst_n(rst_n), .start_i(start), .func_i(fn), .byte_i(bm),
      .shift_ctl_i(ctl), .r0_low_i(r0l), .dst_i(dst), .src_i(src), .status_i(sti),
      .result_o(res1), .status_o(st1), .done_o(dn1), .ovf_req_o(rq1));

   // behavioural model: one bit per step for shifts, integer arithmetic otherwise
   function automatic void ref_op(input int f, input bit b, input bit [5:0] c6, input bit [3:0] rl,
                                  input bit [15:0] d, input bit [15:0] s, input bit [15:0] si,
                                  output bit [15:0] r, output bit [15:0] so);
      int cnt, kind, n, modn, half, a, bb, sa, sb, rv, sv;
      bit [15:0] v;
      bit cyb, ovb, sg;
      so = si;
      if (f == 0) begin
         kind = int'(c6[5:4]);
         cnt  = int'(c6[3:0]);
         if (cnt == 0) cnt = int'(rl);
         if (cnt == 0) cnt = 16;
         v = d; sg = d[15]; cyb = 0; ovb = 0;
         for (int i = 0; i < cnt; i++) begin
            case (kind)
               0: begin cyb = v[0]; v = {v[15], v[15:1]}; end
               1: begin cyb = v[0]; v = {1'b0, v[15:1]}; end
               2: begin cyb = v[15]; v = {v[14:0], 1'b0}; if (v[15] != sg) ovb = 1; end
               default: begin cyb = v[0]; v = {v[0], v[15:1]}; end
            endcase
         end
         r = v;
         so[15] = (v != 0);
         so[14] = (v != 0) && !v[15];
         so[13] = (v == 0);
         so[12] = cyb;
         if (kind == 2) so[11] = ovb;
      end else begin
         n    = b ? 8 : 16;
         modn = 1 << n;
         half = 1 << (n - 1);
         a    = b ? int'(d[7:0]) : int'(d);
         bb   = b ? int'(s[7:0]) : int'(s);
         sa   = (a >= half) ? a - modn : a;
         sb   = (bb >= half) ? bb - modn : bb;
         if (f == 3) begin
            so[15] = bb > a;
            so[14] = sb > sa;
            so[13] = (a == bb);
            r = d;
         end else begin
            if (f == 1) begin
               rv = a + bb; cyb = (rv >= modn); rv = rv % modn; sv = sa + sb;
            end else begin
               rv = a - bb; cyb = (a >= bb); rv = (rv + modn) % modn; sv = sa - sb;
            end
            ovb = (sv >= half) || (sv < -half);
            so[15] = (rv != 0);
            so[14] = (rv != 0) && (rv < half);
            so[13] = (rv == 0);
            so[12] = cyb;
            so[11] = ovb;
            if (b) so[10] = ($countones(rv) % 2) == 1;
            r = 16'(rv);
         end
      end
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [15:0] er, input logic [15:0] es, input logic ed);
      chk(tag, "impl0 result", res0, er);
      chk(tag, "impl0 status", st0, es);
      chk(tag, "impl0 done", 16'(dn0), 16'(ed));
      chk(tag, "impl0 ovf_req", 16'(rq0), 16'(es[5] & es[11]));
      chk(tag, "impl1 result", res1, er);
      chk(tag, "impl1 status", st1, es);
      chk(tag, "impl1 done", 16'(dn1), 16'(ed));
      chk(tag, "impl1 ovf_req", 16'(rq1), 16'(es[5] & es[11]));
   endtask

   task automatic do_op(input string tag, input int f, input bit b, input bit [5:0] c6,
                        input bit [3:0] rl, input bit [15:0] d, input bit [15:0] s, input bit [15:0] si);
      bit [15:0] er, es;
      @(negedge clk);
      fn = 2'(f); bm = b; ctl = c6; r0l = rl; dst = d; src = s; sti = si; start = 1'b1;
      ref_op(f, b, c6, rl, d, s, si, er, es);
      @(negedge clk);
      start = 1'b0;
      chk_all(tag, er, es, 1'b1);
      // idle cycle with scrambled inputs: nothing may move (R1)
      fn = 2'($urandom); bm = 1'($urandom); ctl = 6'($urandom); r0l = 4'($urandom);
      dst = 16'($urandom); src = 16'($urandom); sti = 16'($urandom);
      @(negedge clk);
      chk_all("R1", er, es, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0; start = 0; fn = 0; bm = 0; ctl = 0; r0l = 0; dst = 0; src = 0; sti = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1", 16'h0000, 16'h0000, 1'b0);

      // R2: each shift kind (field [5:4]) with a literal count
      do_op("R2", 0, 0, {2'd0, 4'd3}, 4'd0, 16'h8421, 16'h0, 16'h0000);
      do_op("R2", 0, 0, {2'd1, 4'd3}, 4'd0, 16'h8421, 16'h0, 16'h0000);
      do_op("R2", 0, 0, {2'd2, 4'd4}, 4'd0, 16'h0123, 16'h0, 16'h0000);
      do_op("R2", 0, 0, {2'd3, 4'd4}, 4'd0, 16'h1234, 16'h0, 16'h0000);
      // R3: fallback count from register, then the full-width count
      do_op("R3", 0, 0, {2'd1, 4'd0}, 4'd5, 16'hF0F0, 16'h0, 16'h0000);
      do_op("R3", 0, 0, {2'd0, 4'd0}, 4'd0, 16'h8001, 16'h0, 16'h0000);
      do_op("R3", 0, 0, {2'd3, 4'd0}, 4'd0, 16'hA5C3, 16'h0, 16'h0000);
      do_op("R3", 0, 0, {2'd1, 4'd0}, 4'd0, 16'h8000, 16'h0, 16'h0000);
      // R4: carry is the last bit out
      do_op("R4", 0, 0, {2'd0, 4'd1}, 4'd0, 16'h0001, 16'h0, 16'h0000);
      do_op("R4", 0, 0, {2'd2, 4'd1}, 4'd0, 16'h8000, 16'h0, 16'h0000);
      do_op("R4", 0, 0, {2'd3, 4'd1}, 4'd0, 16'h0001, 16'h0, 16'h0000);
      do_op("R4", 0, 0, {2'd2, 4'd15}, 4'd0, 16'h0002, 16'h0, 16'h1000);
      // R5: left-shift overflow window, and other shifts keep overflow
      do_op("R5", 0, 0, {2'd2, 4'd1}, 4'd0, 16'h3FFF, 16'h0, 16'h0800);
      do_op("R5", 0, 0, {2'd2, 4'd2}, 4'd0, 16'h3FFF, 16'h0, 16'h0000);
      do_op("R5", 0, 0, {2'd2, 4'd0}, 4'd0, 16'hFFFF, 16'h0, 16'h0000);
      do_op("R5", 0, 0, {2'd2, 4'd0}, 4'd0, 16'h0000, 16'h0, 16'h0800);
      do_op("R5", 0, 0, {2'd2, 4'd3}, 4'd0, 16'hE123, 16'h0, 16'h0000);
      do_op("R5", 0, 0, {2'd0, 4'd2}, 4'd0, 16'h7FFF, 16'h0, 16'h0800);
      // R6: zero, negative and positive results
      do_op("R6", 0, 0, {2'd1, 4'd0}, 4'd0, 16'hFFFF, 16'h0, 16'h0000);
      do_op("R6", 0, 0, {2'd0, 4'd1}, 4'd0, 16'h8000, 16'h0, 16'h0000);
      // R7: word add
      do_op("R7", 1, 0, 6'd0, 4'd0, 16'h7FFF, 16'h0001, 16'h0000);
      do_op("R7", 1, 0, 6'd0, 4'd0, 16'hFFFF, 16'h0001, 16'h0000);
      do_op("R7", 1, 0, 6'd0, 4'd0, 16'h8000, 16'h8000, 16'h0000);
      do_op("R7", 1, 0, 6'd0, 4'd0, 16'h1234, 16'h1111, 16'h0400);
      // R8: word subtract
      do_op("R8", 2, 0, 6'd0, 4'd0, 16'h0005, 16'h0003, 16'h0000);
      do_op("R8", 2, 0, 6'd0, 4'd0, 16'h0003, 16'h0005, 16'h0000);
      do_op("R8", 2, 0, 6'd0, 4'd0, 16'h8000, 16'h0001, 16'h0000);
      do_op("R8", 2, 0, 6'd0, 4'd0, 16'h4242, 16'h4242, 16'h0000);
      // R9: byte add and subtract with junk in the upper bytes
      do_op("R9", 1, 1, 6'd0, 4'd0, 16'hAB7F, 16'hCD01, 16'h0000);
      do_op("R9", 2, 1, 6'd0, 4'd0, 16'h1200, 16'h3401, 16'h0000);
      do_op("R9", 1, 1, 6'd0, 4'd0, 16'h00FF, 16'h0001, 16'h0400);
      do_op("R9", 2, 1, 6'd0, 4'd0, 16'hFF80, 16'h0001, 16'h0000);
      // R10: compare, signed versus unsigned, equal, byte; C/OV/P supplied set
      do_op("R10", 3, 0, 6'd0, 4'd0, 16'hFFFF, 16'h0001, 16'h1C00);
      do_op("R10", 3, 0, 6'd0, 4'd0, 16'h0001, 16'hFFFF, 16'h1C00);
      do_op("R10", 3, 0, 6'd0, 4'd0, 16'h5A5A, 16'h5A5A, 16'h0000);
      do_op("R10", 3, 1, 6'd0, 4'd0, 16'h1280, 16'h347F, 16'h1400);
      // R11: low status bits copied
      do_op("R11", 1, 0, 6'd0, 4'd0, 16'h0010, 16'h0020, 16'h03EF);
      do_op("R11", 0, 0, {2'd3, 4'd7}, 4'd0, 16'hBEEF, 16'h0, 16'h0155);
      // R12: overflow request needs both enable and overflow
      do_op("R12", 1, 0, 6'd0, 4'd0, 16'h7FFF, 16'h0001, 16'h0020);
      do_op("R12", 1, 0, 6'd0, 4'd0, 16'h7FFF, 16'h0001, 16'h0000);
      do_op("R12", 2, 0, 6'd0, 4'd0, 16'h0002, 16'h0001, 16'h0820);

      for (int i = 0; i < 400; i++) begin
         int f;
         f = int'($urandom % 4);
         do_op(f == 0 ? "R4" : f == 1 ? "R7" : f == 2 ? "R8" : "R10",
               f, 1'($urandom), 6'($urandom), 4'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom));
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule